// File: doc/BRIEF.md
# Backplane Frame Timing Unit

This block recovers frame timing for 2.048 Mb/s serial backplane streams driven by a 4.096 MHz serial clock. It watches the 8 kHz frame-synchronization line and works out whether the backplane marks frames with a short low-going pulse on a line that normally sits high, or a short high-going pulse on a line that normally sits low. Once two marks of the same polarity arrive exactly one frame apart, it declares lock and reports the detected convention.

While locked it walks through the frame: each bit cell lasts two serial-clock periods, a channel holds `BITS` bit cells, and a frame holds `CHANNELS` channels. It brings out the channel number, the bit index, a bit-boundary enable, a sample enable and a one-cycle start-of-frame strobe. It also brings out two edge selectors that tell the receive and transmit paths which clock edge carries the boundary and which carries the sample. For the low-going convention the boundary is on a falling edge and the sample on a rising edge. For the high-going convention the two are swapped. If marks stop arriving, the count keeps running until a loss window expires, and then lock drops.

The whole block runs on the rising edge of the serial clock. The enables are per-cycle qualifiers, and the edge selectors tell downstream logic which edge of that cycle to act on.

Top module: `frame_timing_unit`

## Requirements
- R1: While reset is held low, `locked`, `sof`, `bnd_en`, `smp_en`, `bnd_fall` and `smp_fall` are 0, and `chan` and `bit_idx` are 0.
- R2: A mark is an excursion of `fsync_in` lasting 1 to `PW_MAX` cycles, preceded by a run of the other level longer than `PW_MAX` cycles. The excursion level is the mark polarity. After lock, `fmt_hi` is 0 for low-going marks and 1 for high-going marks, and it holds steady while lock is held.
- R3: The first mark after loss or reset leaves `locked` at 0. A second mark of the same polarity whose returning edge comes exactly `2*BITS*CHANNELS` cycles after the previous one sets `locked`.
- R4: A mark is acted on two rising edges after `fsync_in` returns to its idle level. In the following cycle `chan` and `bit_idx` are 0, and `sof` is 1 if the block is locked.
- R5: While locked, `bnd_en` and `smp_en` alternate every cycle. `bnd_en` is high in the first cycle of each bit cell and `smp_en` in the second.
- R6: `bit_idx` advances after each sample cycle and wraps from `BITS-1` to 0. `chan` advances when `bit_idx` wraps, and goes from `CHANNELS-1` to 0.
- R7: While locked with `fmt_hi`=0, `bnd_fall`=1 and `smp_fall`=0. With `fmt_hi`=1 the values are swapped. Both are 0 while unlocked.
- R8: An excursion longer than `PW_MAX` cycles is not a mark. If a single expected mark is missing, lock and the channel/bit count carry on unchanged.
- R9: If no mark is acted on for `2*BITS*CHANNELS-1+LOSS_WIN` cycles after the last one, `locked` falls on the next cycle and detection restarts.
- R10: A mark at the wrong spacing, or of the other polarity, clears `locked`. It then counts as the first mark of a new detection.
- R11: While unlocked, `bnd_en`, `smp_en` and `sof` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4.096 MHz serial clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync_in | input | 1 | Frame synchronization line |
| locked | output | 1 | Frame timing acquired |
| fmt_hi | output | 1 | Detected convention: 1 high-going marks, 0 low-going |
| chan | output | $clog2(CHANNELS) | Current channel number |
| bit_idx | output | $clog2(BITS) | Bit index within the channel |
| bnd_en | output | 1 | Bit-boundary cycle enable |
| smp_en | output | 1 | Data-sample cycle enable |
| bnd_fall | output | 1 | Boundary is on the falling edge |
| smp_fall | output | 1 | Sample is on the falling edge |
| sof | output | 1 | Start of frame (channel 0, bit 0, first cycle) |

## Verification
The bench builds the block with `CHANNELS=8`, `BITS=8`, `PW_MAX=4` and `LOSS_WIN=128`. That gives a 128-cycle frame, so dozens of frames, several full loss windows and repeated lock/relock sequences fit in a short run. Setting the loss window equal to the frame length places a single skipped mark exactly on the loss limit, which tests the priority of a mark over a timeout. With the default `PW_MAX`, excursions of every legal width and of the first illegal width can all be driven.

// File: rtl/ftu_pkg.sv
package ftu_pkg;
  // serial clock periods per bit cell
  localparam int CLK_PER_BIT = 2;

  function automatic int frame_len(input int channels, input int bits);
    return CLK_PER_BIT * bits * channels;
  endfunction

  function automatic int gap_limit(input int frame, input int win);
    return frame - 1 + win;
  endfunction

  function automatic int pos_chan(input int p, input int bits);
    return p / (CLK_PER_BIT * bits);
  endfunction

  function automatic int pos_bit(input int p, input int bits);
    return (p / CLK_PER_BIT) % bits;
  endfunction

  function automatic bit pos_is_sample(input int p);
    return (p % CLK_PER_BIT) == (CLK_PER_BIT - 1);
  endfunction

  // run_m1 is run length minus one
  function automatic bit run_is_short(input int run_m1, input int lim);
    return run_m1 < lim;
  endfunction
endpackage

// File: rtl/ftu_pulse_det.sv
module ftu_pulse_det #(
  parameter int PW_MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fsync_in,
  output logic mark,
  output logic mark_pol
);
  localparam int RUN_W = $clog2(PW_MAX + 1);

  logic             fs_q, fs_d, prev_long;
  logic [RUN_W-1:0] run_len;
  logic             edge_seen, ended_short;

  assign edge_seen   = fs_q ^ fs_d;
  assign ended_short = ftu_pkg::run_is_short(int'(run_len), PW_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_q      <= 1'b0;
      fs_d      <= 1'b0;
      prev_long <= 1'b0;
      run_len   <= '0;
    end else begin
      fs_q <= fsync_in;
      fs_d <= fs_q;
      if (edge_seen) begin
        run_len   <= '0;
        prev_long <= !ended_short;
      end else if (run_len != RUN_W'(PW_MAX)) begin
        run_len <= run_len + 1'b1;
      end
    end
  end

  // short excursion that followed a long idle run
  assign mark     = edge_seen && ended_short && prev_long;
  assign mark_pol = fs_d;
endmodule

// File: rtl/ftu_frame_ctr.sv
module ftu_frame_ctr #(
  parameter int FRAME = 512
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mark,
  output logic [$clog2(FRAME)-1:0] pos,
  output logic                     at_end
);
  localparam int POS_W = $clog2(FRAME);

  assign at_end = (pos == POS_W'(FRAME - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)      pos <= '0;
    else if (mark)   pos <= '0;
    else if (at_end) pos <= '0;
    else             pos <= pos + 1'b1;
  end
endmodule

// File: rtl/ftu_lock_fsm.sv
module ftu_lock_fsm #(
  parameter int FRAME    = 512,
  parameter int LOSS_WIN = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mark,
  input  logic mark_pol,
  input  logic at_end,
  output logic locked,
  output logic fmt_hi,
  output logic lose_evt
);
  localparam int LIMIT = ftu_pkg::gap_limit(FRAME, LOSS_WIN);
  localparam int GAP_W = $clog2(LIMIT + 1);

  logic [GAP_W-1:0] gap;
  logic             cand_pol, cand_valid, timeout, agree;

  assign timeout  = (gap == GAP_W'(LIMIT));
  assign lose_evt = timeout && !mark;
  assign agree    = cand_valid && (mark_pol == cand_pol) && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap        <= '0;
      locked     <= 1'b0;
      fmt_hi     <= 1'b0;
      cand_pol   <= 1'b0;
      cand_valid <= 1'b0;
    end else begin
      if (mark)          gap <= '0;
      else if (!timeout) gap <= gap + 1'b1;

      if (mark) begin
        if (agree) begin
          locked <= 1'b1;
          fmt_hi <= mark_pol;
        end else begin
          locked <= 1'b0;
        end
        cand_pol   <= mark_pol;
        cand_valid <= 1'b1;
      end else if (timeout) begin
        locked     <= 1'b0;
        cand_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/frame_timing_unit.sv
module frame_timing_unit #(
  parameter int CHANNELS = 32,
  parameter int BITS     = 8,
  parameter int PW_MAX   = 4,
  parameter int LOSS_WIN = 512
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fsync_in,
  output logic                        locked,
  output logic                        fmt_hi,
  output logic [$clog2(CHANNELS)-1:0] chan,
  output logic [$clog2(BITS)-1:0]     bit_idx,
  output logic                        bnd_en,
  output logic                        smp_en,
  output logic                        bnd_fall,
  output logic                        smp_fall,
  output logic                        sof
);
  localparam int FRAME = ftu_pkg::frame_len(CHANNELS, BITS);
  localparam int POS_W = $clog2(FRAME);
  localparam int CH_W  = $clog2(CHANNELS);
  localparam int BIT_W = $clog2(BITS);

  logic             det_mark, det_pol, lose_evt, at_end, ph_sample;
  logic [POS_W-1:0] pos;

  ftu_pulse_det #(.PW_MAX(PW_MAX)) u_det (
    .clk(clk), .rst_n(rst_n), .fsync_in(fsync_in),
    .mark(det_mark), .mark_pol(det_pol)
  );

  ftu_frame_ctr #(.FRAME(FRAME)) u_ctr (
    .clk(clk), .rst_n(rst_n), .mark(det_mark), .pos(pos), .at_end(at_end)
  );

  ftu_lock_fsm #(.FRAME(FRAME), .LOSS_WIN(LOSS_WIN)) u_lock (
    .clk(clk), .rst_n(rst_n), .mark(det_mark), .mark_pol(det_pol),
    .at_end(at_end), .locked(locked), .fmt_hi(fmt_hi), .lose_evt(lose_evt)
  );

  assign ph_sample = ftu_pkg::pos_is_sample(int'(pos));
  assign chan      = CH_W'(ftu_pkg::pos_chan(int'(pos), BITS));
  assign bit_idx   = BIT_W'(ftu_pkg::pos_bit(int'(pos), BITS));
  assign bnd_en    = locked && !ph_sample;
  assign smp_en    = locked && ph_sample;
  assign sof       = locked && (pos == '0);
  assign bnd_fall  = locked && !fmt_hi;
  assign smp_fall  = locked && fmt_hi;
endmodule

module frame_timing_unit_chk #(
  parameter int CHANNELS = 32,
  parameter int BITS     = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        mark,
  input logic                        lose_evt,
  input logic                        locked,
  input logic                        fmt_hi,
  input logic [$clog2(CHANNELS)-1:0] chan,
  input logic [$clog2(BITS)-1:0]     bit_idx,
  input logic                        bnd_en,
  input logic                        smp_en,
  input logic                        sof
);
  localparam int CH_W  = $clog2(CHANNELS);
  localparam int BIT_W = $clog2(BITS);

  p_fmt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(fmt_hi));

  p_lock_on_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(mark));

  p_zero_after_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mark |=> (chan == '0 && bit_idx == '0 && sof == locked));

  p_alternate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd_en && !mark) |=> (smp_en || !locked));

  p_bit_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && bit_idx == BIT_W'(BITS - 1) && !mark) |=> (bit_idx == '0));

  p_chan_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && bit_idx == BIT_W'(BITS - 1) && chan == CH_W'(CHANNELS - 1) && !mark)
      |=> (chan == '0));

  p_drop_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> ($past(mark) || $past(lose_evt)));
endmodule

bind frame_timing_unit frame_timing_unit_chk #(.CHANNELS(CHANNELS), .BITS(BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .mark(det_mark), .lose_evt(lose_evt),
  .locked(locked), .fmt_hi(fmt_hi), .chan(chan), .bit_idx(bit_idx),
  .bnd_en(bnd_en), .smp_en(smp_en), .sof(sof)
);

// File: tb/frame_timing_unit_bench.sv
module frame_timing_unit_bench;
  localparam int CH    = 8;
  localparam int B     = 8;
  localparam int PW    = 4;
  localparam int LW    = 128;
  localparam int F     = 2 * B * CH;
  localparam int LIMIT = F - 1 + LW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fsync = 1'b1;
  logic locked, fmt_hi, bnd_en, smp_en, bnd_fall, smp_fall, sof;
  logic [$clog2(CH)-1:0] chan;
  logic [$clog2(B)-1:0]  bit_idx;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;
  bit mon_en = 1'b0;
  int mon_zero = 0;
  int mon_fmt = 0;

  always #10 clk = ~clk;

  frame_timing_unit #(.CHANNELS(CH), .BITS(B), .PW_MAX(PW), .LOSS_WIN(LW)) u_frame_timing_unit (
    .clk(clk), .rst_n(rst_n), .fsync_in(fsync), .locked(locked), .fmt_hi(fmt_hi),
    .chan(chan), .bit_idx(bit_idx), .bnd_en(bnd_en), .smp_en(smp_en),
    .bnd_fall(bnd_fall), .smp_fall(smp_fall), .sof(sof)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  // expected position within the frame, derived from cycles since frame zero
  function automatic int exp_off(input int c);
    return (c - mon_zero) % F;
  endfunction

  task automatic monitor();
    int e = exp_off(cyc);
    int in_bit = e % 2;
    chk("R3 locked held", locked, 1);
    chk("R5 bnd_en", bnd_en, (in_bit == 0) ? 1 : 0);
    chk("R5 smp_en", smp_en, in_bit);
    chk("R6 bit_idx", bit_idx, (e % (2 * B)) / 2);
    chk("R6 chan", chan, e / (2 * B));
    chk("R4 sof", sof, (e == 0) ? 1 : 0);
    chk("R2 fmt_hi", fmt_hi, mon_fmt);
    chk("R7 bnd_fall", bnd_fall, 1 - mon_fmt);
    chk("R7 smp_fall", smp_fall, mon_fmt);
  endtask

  task automatic step(input logic v);
    @(negedge clk);
    fsync = v;
    @(posedge clk);
    #2;
    cyc++;
    if (mon_en) monitor();
  endtask

  task automatic idle(input logic lvl, input int n);
    for (int i = 0; i < n; i++) step(lvl);
  endtask

  // excursion of w cycles; returns one cycle after the returning edge
  task automatic pulse(input logic pol, input int w);
    for (int i = 0; i < w; i++) step(pol);
    step(!pol);
    step(!pol);
  endtask

  // next excursion with its returning edge one frame after the previous one
  task automatic frame(input logic pol, input int w);
    idle(!pol, F - w - 2);
    pulse(pol, w);
  endtask

  function automatic int rand_w();
    return 1 + int'($urandom % PW);
  endfunction

  task automatic expect_lock(input string tag, input int pol);
    chk({tag, " locked"}, locked, 1);
    chk("R4 sof at lock", sof, 1);
    chk("R4 chan zero", chan, 0);
    chk("R4 bit zero", bit_idx, 0);
    chk("R2 fmt_hi at lock", fmt_hi, pol);
    chk("R7 bnd_fall at lock", bnd_fall, 1 - pol);
    chk("R7 smp_fall at lock", smp_fall, pol);
    mon_zero = cyc;
    mon_fmt  = pol;
  endtask

  initial begin
    int unsigned seed_init;
    int w;
    seed_init = $urandom(32'd2024);

    // R1: reset state
    for (int i = 0; i < 4; i++) step(1'b1);
    chk("R1 locked", locked, 0);
    chk("R1 sof", sof, 0);
    chk("R1 bnd_en", bnd_en, 0);
    chk("R1 smp_en", smp_en, 0);
    chk("R1 bnd_fall", bnd_fall, 0);
    chk("R1 smp_fall", smp_fall, 0);
    chk("R1 chan", chan, 0);
    chk("R1 bit_idx", bit_idx, 0);
    rst_n = 1'b1;

    // low-going convention
    idle(1'b1, 40);
    pulse(1'b0, rand_w());
    chk("R3 first mark unlocked", locked, 0);
    chk("R11 sof unlocked", sof, 0);
    chk("R11 bnd_en unlocked", bnd_en, 0);
    frame(1'b0, rand_w());
    expect_lock("R3 low-going", 0);
    mon_en = 1'b1;
    for (int i = 0; i < 3; i++) frame(1'b0, rand_w());
    // R9: no more marks, flywheel until the loss limit
    idle(1'b1, LIMIT);
    chk("R9 held at limit", locked, 1);
    mon_en = 1'b0;
    idle(1'b1, 1);
    chk("R9 lost after limit", locked, 0);
    idle(1'b1, 3);
    chk("R11 bnd_en after loss", bnd_en, 0);
    chk("R11 smp_en after loss", smp_en, 0);
    chk("R7 bnd_fall after loss", bnd_fall, 0);

    // high-going convention, with a too-wide excursion
    idle(1'b0, 30);
    pulse(1'b1, PW);
    chk("R3 first high mark unlocked", locked, 0);
    frame(1'b1, 1);
    expect_lock("R3 high-going", 1);
    mon_en = 1'b1;
    frame(1'b1, rand_w());
    frame(1'b1, PW + 1);            // R8: not a mark, count flies on
    chk("R8 wide ignored", locked, 1);
    frame(1'b1, rand_w());           // mark lands on the loss limit
    chk("R8 lock kept across skipped mark", locked, 1);
    chk("R8 sof after skipped mark", sof, 1);

    // R10: mark at the wrong spacing
    mon_en = 1'b0;
    w = rand_w();
    idle(1'b0, F - w - 2 - 20);
    pulse(1'b1, w);
    chk("R10 misplaced mark drops lock", locked, 0);
    chk("R10 sof after misplaced", sof, 0);
    frame(1'b1, rand_w());
    expect_lock("R10 relock", 1);
    mon_en = 1'b1;
    frame(1'b1, rand_w());

    // R10: other polarity
    mon_en = 1'b0;
    idle(1'b0, 50);
    idle(1'b1, 10);
    pulse(1'b0, rand_w());
    chk("R10 other polarity drops lock", locked, 0);
    frame(1'b0, rand_w());
    expect_lock("R10 relock other polarity", 0);

    // random rounds, each started after a full loss
    for (int r = 0; r < 4; r++) begin
      logic p;
      int nf;
      p  = logic'($urandom % 2);
      nf = 1 + int'($urandom % 3);
      mon_en = 1'b0;
      idle(!p, LIMIT + 10);
      chk("R9 unlocked before round", locked, 0);
      pulse(p, rand_w());
      chk("R3 round first mark", locked, 0);
      frame(p, rand_w());
      expect_lock("R3 round lock", int'(p));
      mon_en = 1'b1;
      for (int i = 0; i < nf; i++) frame(p, rand_w());
      idle(!p, int'($urandom % F));
    end
    mon_en = 1'b0;

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog expired at cycle %0d: actual=running expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule